// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block derives two logic-level timing strobes for a video preamplifier's clamp circuits: an input clamp strobe (`bpcp`) that marks the back porch of every line, and an output clamp strobe (`ocl`) that gates the output black-level sample-and-hold. Both come from two asynchronous pins, a horizontal sync and a blanking pulse, sampled on a fixed-frequency system clock. Register-style configuration inputs pick the trigger pin, the trigger edge, the blanking polarity and the strobe width. Separate controls provide a sync pass-through and test forcing.

Both pins pass through a two-flop synchroniser. The sync polarity is learned from the line itself. A run counter times the high and low phases. At each rising sync edge the low phase that has just ended is compared with the latest high phase, and whichever is shorter is taken as the active sync pulse. The strobe is timed by a reloadable down-counter in whole width units. A new trigger that arrives during a strobe restarts it.

The polarity learner has three states. `P_WAIT` means no edge has been seen since reset. `P_HIGH` counts the synchronised sync while it is high and is entered on every rising edge. `P_LOW` counts it while it is low and is entered on every falling edge. The strobe timer has two states. `S_IDLE` moves to `S_RUN` on a trigger. `S_RUN` stays in `S_RUN` and reloads on a trigger, and returns to `S_IDLE` when the count reaches one.

Top module: `clamp_pulse_gen`

## Requirements
- R1: A qualifying pin edge that is set up before clock edge k makes `bpcp` go high after clock edge k+2, which is two synchroniser stages plus one timer register.
- R2: `src_blk`=0 triggers the strobe from the sync pin only, and `src_blk`=1 triggers it from the leading edge of the active blanking pulse only. Activity on the unselected pin has no effect on `bpcp`.
- R3: With the sync source, `hs_lead`=1 triggers on the leading edge of the active sync pulse and `hs_lead`=0 triggers on its trailing edge.
- R4: Sync polarity is learned. After reset the pulse is taken as active-high. At each rising sync edge the polarity becomes active-low if the low phase that has just ended is shorter than the latest high phase, and active-high otherwise. The decision changes at no other time.
- R5: `blk_active_low`=0 treats a high blanking pin as active, and `blk_active_low`=1 treats a low pin as active. Only the leading edge of the active level triggers.
- R6: `width_sel` codes 0, 1, 2 and 3 give a strobe of 4, 8, 12 and 16 clocks respectively (code+1 times `UNIT_CLKS`, default 4).
- R7: A trigger that arrives while a strobe is running restarts the full width from that trigger.
- R8: `pass_thru`=1 drives `bpcp` from the synchronised sync pin level, two clocks after the pin, regardless of source, edge or width settings.
- R9: `force_bpcp`=1 holds `bpcp` at 1 in the same cycle, overriding every other mode.
- R10: `force_ocl`=1 holds `ocl` at 1 in the same cycle.
- R11: `ocl_sel_bpcp`=0 makes `ocl` the active-high blanking level (after polarity), two clocks after the pin. `ocl_sel_bpcp`=1 makes `ocl` equal to `bpcp`.
- R12: While reset is asserted, with both pins low and all controls at 0, `bpcp` and `ocl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_in | input | 1 | Asynchronous horizontal sync pin |
| blk_in | input | 1 | Asynchronous blanking pin |
| src_blk | input | 1 | Trigger source: 0 sync, 1 blanking |
| hs_lead | input | 1 | Sync edge: 0 trailing, 1 leading |
| blk_active_low | input | 1 | Blanking polarity: 0 active-high, 1 active-low |
| width_sel | input | WSEL_W (2) | Strobe width code |
| pass_thru | input | 1 | Drive bpcp from the synchronised sync pin |
| force_bpcp | input | 1 | Test: force bpcp to 1 |
| force_ocl | input | 1 | Test: force ocl to 1 |
| ocl_sel_bpcp | input | 1 | ocl source: 0 blanking level, 1 bpcp |
| bpcp | output | 1 | Back-porch clamp strobe |
| ocl | output | 1 | Output clamp strobe |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a 4-clock width unit, a 2-bit width code and a 10-bit run counter. Under these values the widest strobe, 16 clocks, fits inside a sync pulse of 20 clocks or more. Leading-edge strobes, trailing-edge strobes and restarts can therefore each be seen in full within lines of about a hundred clocks. The run counter does not saturate on those lines, so every polarity decision is a real comparison of phase lengths. The random lines change polarity, edge and width from block to block. Each such change is followed by warm-up lines that cover the one-line lag of the polarity learner.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    // Polarity learner states
    typedef enum logic [1:0] {
        P_WAIT = 2'd0,
        P_HIGH = 2'd1,
        P_LOW  = 2'd2
    } pol_state_e;

    // Strobe timer states
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } tmr_state_e;

endpackage

// File: rtl/cpg_sync.sv
module cpg_sync #(
    parameter int STAGES = 2,
    parameter int N      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_in,
    output logic [N-1:0] q_out,
    output logic [N-1:0] q_prev
);

    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            logic              prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain  <= '0;
                    prev_q <= 1'b0;
                end else begin
                    chain[0] <= d_in[b];
                    for (int s = 1; s < STAGES; s++) begin
                        chain[s] <= chain[s-1];
                    end
                    prev_q <= chain[STAGES-1];
                end
            end

            assign q_out[b]  = chain[STAGES-1];
            assign q_prev[b] = prev_q;
        end
    endgenerate

endmodule

// File: rtl/cpg_polarity.sv
module cpg_polarity
    import cpg_pkg::*;
#(
    parameter int RUN_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_rise,
    input  logic hs_fall,
    output logic neg_pol
);

    pol_state_e       state_q, state_d;
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] high_len_q;
    logic             have_high_q;
    logic             neg_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= P_WAIT;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            P_WAIT: begin
                if (hs_rise)      state_d = P_HIGH;
                else if (hs_fall) state_d = P_LOW;
            end
            P_HIGH: if (hs_fall) state_d = P_LOW;
            P_LOW:  if (hs_rise) state_d = P_HIGH;
            default: state_d = P_WAIT;
        endcase
    end

    // Phase timing and decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            high_len_q  <= '0;
            have_high_q <= 1'b0;
            neg_q       <= 1'b0;
        end else begin
            if (hs_rise || hs_fall) begin
                run_q <= '0;
            end else if (run_q != '1) begin
                run_q <= run_q + 1'b1;
            end
            if (hs_fall && state_q == P_HIGH) begin
                high_len_q  <= run_q;
                have_high_q <= 1'b1;
            end
            if (hs_rise && state_q == P_LOW && have_high_q) begin
                neg_q <= (run_q < high_len_q);
            end
        end
    end

    assign neg_pol = neg_q;

    // R4: decision moves only at a rising sync edge
    assert_pol_line_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_rise |=> $stable(neg_q));

    // R4: active-high until edges have been seen
    assert_pol_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == P_WAIT) |-> !neg_q);

endmodule

// File: rtl/cpg_timer.sv
module cpg_timer
    import cpg_pkg::*;
#(
    parameter int UNIT_CLKS = 4,
    parameter int WSEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [WSEL_W-1:0] width_sel,
    output logic              active
);

    localparam int MAX_LEN = UNIT_CLKS * (1 << WSEL_W);
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'((32'(width_sel) + 32'd1) * UNIT_CLKS);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (trig) begin
                    state_d = S_RUN;
                    cnt_d   = load_val;
                end
            end
            S_RUN: begin
                if (trig) begin
                    cnt_d = load_val;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = S_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = S_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Output process
    always_comb begin
        active = (state_q == S_RUN);
    end

    // R1: a trigger starts the strobe on the next cycle
    assert_trig_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (state_q == S_RUN));

    // R7: a trigger always reloads the full width
    assert_restart_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == $past(load_val)));

    // R6: a running count stays inside the widest width
    assert_width_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN) |-> (cnt_q != '0 && 32'(cnt_q) <= MAX_LEN));

endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
    parameter int SYNC_STAGES = 2,
    parameter int UNIT_CLKS   = 4,
    parameter int WSEL_W      = 2,
    parameter int RUN_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync_in,
    input  logic              blk_in,
    input  logic              src_blk,
    input  logic              hs_lead,
    input  logic              blk_active_low,
    input  logic [WSEL_W-1:0] width_sel,
    input  logic              pass_thru,
    input  logic              force_bpcp,
    input  logic              force_ocl,
    input  logic              ocl_sel_bpcp,
    output logic              bpcp,
    output logic              ocl
);

    localparam int NPIN   = 2;
    localparam int HS_IDX = 0;
    localparam int BK_IDX = 1;

    logic [NPIN-1:0] pin_now, pin_prev;
    logic hs_now, hs_prev, hs_rise, hs_fall;
    logic neg_pol;
    logic hs_lead_edge, hs_trail_edge;
    logic blk_act, blk_act_prev, blk_lead_edge;
    logic trig;
    logic strobe_active;

    cpg_sync #(
        .STAGES(SYNC_STAGES),
        .N     (NPIN)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({blk_in, hsync_in}),
        .q_out (pin_now),
        .q_prev(pin_prev)
    );

    assign hs_now  = pin_now[HS_IDX];
    assign hs_prev = pin_prev[HS_IDX];
    assign hs_rise = hs_now & ~hs_prev;
    assign hs_fall = ~hs_now & hs_prev;

    cpg_polarity #(
        .RUN_W(RUN_W)
    ) u_pol (
        .clk    (clk),
        .rst_n  (rst_n),
        .hs_rise(hs_rise),
        .hs_fall(hs_fall),
        .neg_pol(neg_pol)
    );

    // Edges of the active sync pulse, independent of pin polarity
    assign hs_lead_edge  = neg_pol ? hs_fall : hs_rise;
    assign hs_trail_edge = neg_pol ? hs_rise : hs_fall;

    // Blanking normalised to active-high
    assign blk_act       = pin_now[BK_IDX]  ^ blk_active_low;
    assign blk_act_prev  = pin_prev[BK_IDX] ^ blk_active_low;
    assign blk_lead_edge = blk_act & ~blk_act_prev;

    always_comb begin
        if (src_blk)      trig = blk_lead_edge;
        else if (hs_lead) trig = hs_lead_edge;
        else              trig = hs_trail_edge;
    end

    cpg_timer #(
        .UNIT_CLKS(UNIT_CLKS),
        .WSEL_W   (WSEL_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .width_sel(width_sel),
        .active   (strobe_active)
    );

    always_comb begin
        bpcp = force_bpcp | (pass_thru ? hs_now : strobe_active);
        ocl  = force_ocl  | (ocl_sel_bpcp ? bpcp : blk_act);
    end

    // R9: forcing wins over every mode
    assert_force_bpcp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        force_bpcp |-> bpcp);

    // R10: forcing the output clamp strobe
    assert_force_ocl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        force_ocl |-> ocl);

    // R2: with the blanking source, sync edges alone never start a strobe
    assert_src_isolation_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_blk && !blk_lead_edge) |-> !trig);

endmodule

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       blk_in = 1'b0;
    logic       src_blk = 1'b0;
    logic       hs_lead = 1'b0;
    logic       blk_active_low = 1'b0;
    logic [1:0] width_sel = 2'd0;
    logic       pass_thru = 1'b0;
    logic       force_bpcp = 1'b0;
    logic       force_ocl = 1'b0;
    logic       ocl_sel_bpcp = 1'b0;
    logic       bpcp, ocl;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clamp_pulse_gen u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_in      (hsync_in),
        .blk_in        (blk_in),
        .src_blk       (src_blk),
        .hs_lead       (hs_lead),
        .blk_active_low(blk_active_low),
        .width_sel     (width_sel),
        .pass_thru     (pass_thru),
        .force_bpcp    (force_bpcp),
        .force_ocl     (force_ocl),
        .ocl_sel_bpcp  (ocl_sel_bpcp),
        .bpcp          (bpcp),
        .ocl           (ocl)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Expected strobe width from R6
    function automatic int width_of(input int code);
        return (code + 1) * 4;
    endfunction

    function automatic bit in_win(input int i, input int s, input int e);
        return (i >= s) && (i < e);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Step n cycles; bpcp (sel=0) or ocl (sel=1) expected high for s <= i < e
    task automatic watch(input int n, input int s, input int e, input bit sel,
                         input bit do_chk, input string req);
        int bad = 0;
        int first = -1;
        int got = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if ((sel ? ocl : bpcp) !== in_win(i, s, e)) begin
                bad++;
                if (first < 0) begin
                    first = i;
                    got = sel ? int'(ocl) : int'(bpcp);
                end
            end
        end
        if (do_chk)
            check(bad == 0, req, $sformatf("window mismatches=%0d first_step=%0d level", bad, first),
                  got, first < 0 ? got : 1 - got);
    endtask

    // One sync line; strobe at sample 3 after the selected edge (R1)
    task automatic hs_line(input bit neg, input int sync_len, input int gap_len,
                           input bit lead, input int code, input bit do_chk, input string req);
        int w = width_of(code);
        hs_lead   = lead;
        width_sel = 2'(code);
        hsync_in  = ~neg;
        watch(sync_len, lead ? 3 : 999, lead ? 3 + w : 999, 1'b0, do_chk, req);
        hsync_in  = neg;
        watch(gap_len, lead ? 999 : 3, lead ? 999 : 3 + w, 1'b0, do_chk, req);
    endtask

    initial begin
        void'($urandom(32'd20240607));

        // R12: reset state
        repeat (4) @(negedge clk);
        check(bpcp == 1'b0, "R12", "bpcp in reset", int'(bpcp), 0);
        check(ocl == 1'b0, "R12", "ocl in reset", int'(ocl), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 default active-high, R1 latency, R3 leading edge, R6 width codes
        hs_line(1'b0, 24, 60, 1'b1, 0, 1'b1, "R4_R1");
        for (int c = 0; c < 4; c++) hs_line(1'b0, 24, 60, 1'b1, c, 1'b1, "R6");
        // R3 trailing edge
        for (int c = 0; c < 4; c += 3) hs_line(1'b0, 24, 60, 1'b0, c, 1'b1, "R3");

        // R4 learned active-low sync
        hsync_in = 1'b1;
        for (int k = 0; k < 3; k++) hs_line(1'b1, 24, 70, 1'b1, 1, 1'b0, "warm");
        hs_line(1'b1, 24, 70, 1'b1, 1, 1'b1, "R4_lead");
        hs_line(1'b1, 24, 70, 1'b0, 2, 1'b1, "R4_trail");
        for (int k = 0; k < 3; k++) hs_line(1'b0, 24, 70, 1'b1, 1, 1'b0, "warm");

        // R2: blanking activity ignored with the sync source
        blk_in = 1'b1; watch(25, 999, 999, 1'b0, 1'b1, "R2_blk_ignored");
        blk_in = 1'b0; watch(25, 999, 999, 1'b0, 1'b1, "R2_blk_ignored");

        // R2: sync activity ignored with the blanking source
        src_blk = 1'b1; width_sel = 2'd1;
        hsync_in = 1'b1; watch(25, 999, 999, 1'b0, 1'b1, "R2_hs_ignored");
        hsync_in = 1'b0; watch(25, 999, 999, 1'b0, 1'b1, "R2_hs_ignored");

        // R2/R5: positive blanking leading edge
        blk_in = 1'b1; watch(25, 3, 3 + width_of(1), 1'b0, 1'b1, "R2_R5_pos");
        blk_in = 1'b0; watch(30, 999, 999, 1'b0, 1'b1, "R5_trail_ignored");

        // R5: active-low blanking
        blk_active_low = 1'b1; watch(5, 999, 999, 1'b0, 1'b1, "R5_cfg_no_edge");
        blk_in = 1'b1; watch(25, 999, 999, 1'b0, 1'b1, "R5_neg_trail");
        blk_in = 1'b0; watch(25, 3, 3 + width_of(1), 1'b0, 1'b1, "R5_neg_lead");
        blk_active_low = 1'b0; watch(20, 999, 999, 1'b0, 1'b1, "R5_cfg_back");

        // R7: restart during a running strobe (width 16)
        width_sel = 2'd3;
        blk_in = 1'b1; watch(4, 3, 999, 1'b0, 1'b1, "R7_a");
        blk_in = 1'b0; watch(4, 0, 999, 1'b0, 1'b1, "R7_b");
        blk_in = 1'b1; watch(4, 0, 999, 1'b0, 1'b1, "R7_c");
        blk_in = 1'b0; watch(30, 0, 15, 1'b0, 1'b1, "R7_restart_end");

        // R11: ocl follows blanking level
        ocl_sel_bpcp = 1'b0; src_blk = 1'b0;
        blk_in = 1'b1; watch(10, 2, 999, 1'b1, 1'b1, "R11_blk_level");
        blk_in = 1'b0; watch(10, 0, 2, 1'b1, 1'b1, "R11_blk_level");
        blk_active_low = 1'b1; watch(4, 0, 999, 1'b1, 1'b1, "R11_inverted");
        blk_active_low = 1'b0;

        // R11: ocl equals bpcp
        ocl_sel_bpcp = 1'b1;
        hs_line(1'b0, 24, 60, 1'b1, 2, 1'b0, "R11");
        hsync_in = 1'b1; watch(24, 3, 3 + width_of(2), 1'b1, 1'b1, "R11_from_bpcp");
        hsync_in = 1'b0; watch(40, 999, 999, 1'b1, 1'b1, "R11_from_bpcp");
        ocl_sel_bpcp = 1'b0;

        // R9/R10: test forcing, same cycle
        force_bpcp = 1'b1; #1;
        check(bpcp == 1'b1, "R9", "forced bpcp", int'(bpcp), 1);
        force_ocl = 1'b1; #1;
        check(ocl == 1'b1, "R10", "forced ocl", int'(ocl), 1);
        @(negedge clk);
        force_bpcp = 1'b0; force_ocl = 1'b0; #1;
        check(bpcp == 1'b0 && ocl == 1'b0, "R9_R10", "released",
              int'(bpcp) + int'(ocl), 0);
        @(negedge clk);

        // R8: pass-through, sample 2 after the pin
        pass_thru = 1'b1; width_sel = 2'd0;
        hsync_in = 1'b1; watch(30, 2, 999, 1'b0, 1'b1, "R8_pass_high");
        hsync_in = 1'b0; watch(10, 0, 2, 1'b0, 1'b1, "R8_pass_low");
        pass_thru = 1'b0;
        watch(30, 999, 999, 1'b0, 1'b0, "settle");

        // Random lines: polarity, edge and width change per block
        for (int blk = 0; blk < 12; blk++) begin
            bit neg  = 1'($urandom % 2);
            bit lead = 1'($urandom % 2);
            int code = int'($urandom % 4);
            for (int k = 0; k < 5; k++) begin
                int sl = 20 + int'($urandom % 11);
                int gl = 40 + int'($urandom % 50);
                hs_line(neg, sl, gl, lead, code, k >= 3,
                        lead ? "R3_R4_R6_rand_lead" : "R3_R4_R6_rand_trail");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule